// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast system clock into the bit-rate strobe a serial shifter needs. The rate is set by two numbers instead of one integer divisor. A coarse integer prescaler divides the clock by `scale + 1`. A fine fractional stage then adds `step` into a phase accumulator that is one bit wider than `step`. Every carry out of that accumulator produces a one-cycle strobe, so the mean strobe rate is `f_clk / (scale + 1) * step / 2^17` with the default widths.

Software picks the scale/step pair for the rate it wants and writes both fields at once through a single configuration word. A write restarts the prescaler and the accumulator from zero, so the new rate begins from a known phase. Dropping the enable holds both stages at zero. A step of zero gives a silent output.

Top module: `frac_baud_gen`

## Requirements
- R1: With the default widths, the number of ticks seen in the L cycles that follow the first add after a configuration write equals floor(P * step / 2^17), where P = ceil(L / (scale + 1)) is the number of adds in that window.
- R2: The configuration word carries step in bits [15:0] and scale in bits [23:16]. Both fields are loaded together on the clock edge where `cfg_we` is high.
- R3: While enabled, the prescaler grants one add every scale + 1 cycles. The first add falls in the first enabled cycle after a write, a reset or a re-enable. With a nonzero scale, two adds are never granted in consecutive cycles.
- R4: `baud_tick` is high for exactly one cycle per carry and is never high in two consecutive cycles.
- R5: `baud_tick` is registered. It rises in the cycle after the add that carried out of the accumulator, and only then.
- R6: A configuration write clears the prescaler and the accumulator. `baud_tick` is low in the cycle after the write, and the tick pattern then starts again from phase zero.
- R7: A step of zero produces no ticks for any scale.
- R8: While `en` is low, `baud_tick` stays low from the next cycle on and both stages are held at zero. After `en` returns high, the pattern starts from phase zero (scale 0, step 0x8000: first tick in the 4th cycle).
- R9: After reset, `baud_tick` is low and the configuration is all zeros, so no ticks appear until a write.
- R10: The extremes are exact. Scale 0 with step 0xFFFF gives 499 ticks over 1000 cycles. Scale 0xFF gives one add every 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds both stages at zero |
| cfg_we | input | 1 | Loads `cfg_word` and restarts the phase |
| cfg_word | input | 24 | Packed step [15:0] and scale [23:16] |
| baud_tick | output | 1 | One-cycle strobe at the programmed rate |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. These are: the tick is one cycle wide, no tick appears after a write, while disabled or with a zero step, every tick follows an add, and prescaler grants are spaced when scale is nonzero. Long-run behaviour can only be shown by the bench scenarios, which compare against a reference that derives ticks from the running product of add count and step. That behaviour covers the exact tick count over a window, the placement of the scale and step fields in the word, the restart phase after a write or re-enable, and the rate at the extreme settings.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    // Default field widths of the configuration word
    localparam int unsigned FBG_SCALE_W = 8;
    localparam int unsigned FBG_STEP_W  = 16;

    // Control command shared by the prescaler and the accumulator
    typedef enum logic [1:0] {
        FBG_HOLD    = 2'd0,   // disabled: stages parked at zero
        FBG_RESTART = 2'd1,   // configuration write: stages cleared
        FBG_RUN     = 2'd2    // normal counting
    } fbg_ctl_e;

    function automatic fbg_ctl_e fbg_decode_ctl(input logic we, input logic run_en);
        fbg_ctl_e c;
        if (we)
            c = FBG_RESTART;
        else if (!run_en)
            c = FBG_HOLD;
        else
            c = FBG_RUN;
        return c;
    endfunction

endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg
    import fbg_pkg::*;
#(
    parameter int unsigned SCALE_W = FBG_SCALE_W,
    parameter int unsigned STEP_W  = FBG_STEP_W,
    localparam int unsigned CFG_W  = SCALE_W + STEP_W,
    localparam int unsigned SCALE_LSB = STEP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_word,
    output logic [SCALE_W-1:0] scale,
    output logic [STEP_W-1:0]  step
);

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [STEP_W-1:0]  step;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d.step  = cfg_word[STEP_W-1:0];
            state_d.scale = cfg_word[SCALE_LSB +: SCALE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign scale = state_q.scale;
    assign step  = state_q.step;

endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler
    import fbg_pkg::*;
#(
    parameter int unsigned SCALE_W = FBG_SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  fbg_ctl_e           ctl,
    input  logic [SCALE_W-1:0] scale,
    output logic               add_pulse
);

    typedef struct packed {
        logic [SCALE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t state_d, state_q;
    logic       pulse_d;

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        unique case (ctl)
            FBG_RUN: begin
                if (state_q.cnt == '0) begin
                    pulse_d     = 1'b1;
                    state_d.cnt = scale;
                end else begin
                    state_d.cnt = state_q.cnt - 1'b1;
                end
            end
            default: begin
                state_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign add_pulse = pulse_d;

endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc
    import fbg_pkg::*;
#(
    parameter int unsigned STEP_W = FBG_STEP_W,
    localparam int unsigned ACC_W = STEP_W + 1,
    localparam int unsigned SUM_W = ACC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fbg_ctl_e          ctl,
    input  logic              add_pulse,
    input  logic [STEP_W-1:0] step,
    output logic              tick
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_state_t;

    acc_state_t       state_d, state_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, state_q.acc} + {{(SUM_W-STEP_W){1'b0}}, step};
        state_d = state_q;
        state_d.tick = 1'b0;
        unique case (ctl)
            FBG_RUN: begin
                if (add_pulse) begin
                    state_d.acc  = sum[ACC_W-1:0];
                    state_d.tick = sum[ACC_W];
                end
            end
            default: begin
                state_d.acc = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign tick = state_q.tick;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int unsigned SCALE_W = FBG_SCALE_W,
    parameter int unsigned STEP_W  = FBG_STEP_W,
    localparam int unsigned CFG_W  = SCALE_W + STEP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             baud_tick
);

    logic [SCALE_W-1:0] scale_cur;
    logic [STEP_W-1:0]  step_cur;
    logic               add_pulse;
    fbg_ctl_e           ctl;

    assign ctl = fbg_decode_ctl(cfg_we, en);

    fbg_cfg_reg #(
        .SCALE_W (SCALE_W),
        .STEP_W  (STEP_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_word (cfg_word),
        .scale    (scale_cur),
        .step     (step_cur)
    );

    fbg_prescaler #(
        .SCALE_W (SCALE_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .scale     (scale_cur),
        .add_pulse (add_pulse)
    );

    fbg_phase_acc #(
        .STEP_W (STEP_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .add_pulse (add_pulse),
        .step      (step_cur),
        .tick      (baud_tick)
    );

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
    parameter int unsigned SCALE_W = 8,
    parameter int unsigned STEP_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               cfg_we,
    input logic               tick,
    input logic               add_pulse,
    input logic [SCALE_W-1:0] scale_q,
    input logic [STEP_W-1:0]  step_q
);

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                              // R4

    AST_TICK_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(add_pulse));                                   // R5

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !tick);                                            // R6

    AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == '0) |=> !tick);                                    // R7

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);                                               // R8

    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (add_pulse && scale_q != '0) |=> !add_pulse);                 // R3

endmodule

bind frac_baud_gen fbg_checker #(
    .SCALE_W (SCALE_W),
    .STEP_W  (STEP_W)
) u_fbg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cfg_we    (cfg_we),
    .tick      (baud_tick),
    .add_pulse (add_pulse),
    .scale_q   (scale_cur),
    .step_q    (step_cur)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        baud_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    frac_baud_gen u_frac_baud_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cfg_we    (cfg_we),
        .cfg_word  (cfg_word),
        .baud_tick (baud_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: ticks come from the growth of floor(adds * step / 2^17)
    longint m_scale = 0, m_step = 0, m_cyc = 0, m_adds = 0;
    logic   exp_tick = 1'b0;
    logic   prev_tick = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scale = 0; m_step = 0; m_cyc = 0; m_adds = 0; exp_tick = 1'b0;
        end else if (cfg_we) begin
            m_step  = cfg_word[15:0];
            m_scale = cfg_word[23:16];
            m_cyc = 0; m_adds = 0; exp_tick = 1'b0;
        end else if (!en) begin
            m_cyc = 0; m_adds = 0; exp_tick = 1'b0;
        end else begin
            if (m_cyc % (m_scale + 1) == 0) begin
                m_adds = m_adds + 1;
                exp_tick = ((m_adds * m_step) >> 17) != (((m_adds - 1) * m_step) >> 17);
            end else begin
                exp_tick = 1'b0;
            end
            m_cyc = m_cyc + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 tick vs reference", baud_tick, exp_tick);
            if (prev_tick && baud_tick)
                chk("R4 consecutive ticks", 1, 0);
            prev_tick = baud_tick;
        end else begin
            prev_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_cfg(input logic [7:0] sc, input logic [15:0] st);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_word = {sc, st};
        @(negedge clk);
        chk("R6 tick after write", baud_tick, 0);
        cfg_we = 1'b0;
    endtask

    task automatic count_ticks(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            n += int'(baud_tick);
        end
    endtask

    task automatic first_tick(input int len, output int idx);
        idx = -1;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (baud_tick && idx < 0) idx = i;
        end
    endtask

    initial begin
        int n;
        int idx;
        repeat (3) @(negedge clk);
        chk("R9 tick in reset", baud_tick, 0);
        rst_n = 1'b1;
        en    = 1'b1;
        count_ticks(50, n);
        chk("R9 no ticks before first write", n, 0);

        write_cfg(8'd0, 16'h4000);
        count_ticks(800, n);
        chk("R1 scale0 step4000 count", n, 100);

        write_cfg(8'd3, 16'h8000);
        count_ticks(1600, n);
        chk("R3 scale3 step8000 count", n, 100);

        write_cfg(8'd1, 16'h2000);
        count_ticks(640, n);
        chk("R2 field placement count", n, 20);

        write_cfg(8'd0, 16'h0000);
        count_ticks(500, n);
        chk("R7 zero step", n, 0);
        write_cfg(8'd9, 16'h0000);
        count_ticks(300, n);
        chk("R7 zero step scale9", n, 0);

        write_cfg(8'd0, 16'hFFFF);
        count_ticks(1000, n);
        chk("R10 fastest count", n, 499);
        write_cfg(8'hFF, 16'h8000);
        count_ticks(2048, n);
        chk("R10 slowest scale count", n, 2);

        write_cfg(8'd0, 16'h8000);
        count_ticks(10, n);
        @(negedge clk);
        en = 1'b0;
        count_ticks(20, n);
        chk("R8 disabled ticks", n, 0);
        en = 1'b1;
        first_tick(10, idx);
        chk("R8 restart phase after enable", idx, 4);

        write_cfg(8'd0, 16'h8000);
        count_ticks(6, n);
        write_cfg(8'd0, 16'h8000);
        first_tick(10, idx);
        chk("R6 restart phase after write", idx, 4);

        write_cfg(8'd2, 16'h8000);
        first_tick(20, idx);
        chk("R3 first add in first cycle", idx, 10);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule